// File: doc/BRIEF.md
# Fixed-Address DMA Channel Engine

This block is one DMA channel that moves data between a memory location and a peripheral register without ever stepping either address. Every pulse on the transfer-request input starts exactly one transfer of one byte or one 16-bit word. A transfer is a read bus cycle from the source address followed by a write bus cycle to the destination address. The value read is held inside the block between the two cycles. A 16-bit down-counter counts the transfers. When it runs out, the channel switches itself off and raises a level interrupt.

The memory-side address is a full 24-bit register. The peripheral-side register holds only a 16-bit offset, and the block always places that offset in the top 64 KiB page of the address space. One direction bit chooses which of the two addresses is read and which is written. Software programs the channel through a small write-only register port, and reads its state back from the enable and interrupt pins.

The bus-master port is a valid/ready handshake. The block raises `bus_valid` with the address, direction, size and (for writes) data. It holds all of them unchanged until the slave answers with `bus_ready` in the same cycle. The slave may hold `bus_ready` low for any number of cycles to stall the channel. The channel never withdraws a cycle once it has offered it.

Top module: `fixed_dma_channel`

## Requirements
- R1: Requests are serviced only while the control register has all three of these bits at 1: enable (bit 0), repeat-enable (bit 3) and end-interrupt-enable (bit 4). The register port writes the mode address with `cfg_sel`=0, the peripheral offset with 1, the count with 2 and control with 3.
- R2: Each request produces one read cycle (`bus_write`=0) followed by one write cycle (`bus_write`=1). The write cycle carries the data that was read. In byte mode (control bit 2 = 0) the upper byte of `bus_wdata` is zero.
- R3: Every transfer uses the same memory-side address, and no transfer changes it.
- R4: The peripheral-side bus address is {8'hFF, offset}, and it is the same on every transfer.
- R5: When the direction bit (control bit 1) is 0, the memory address is read and the peripheral address is written. When it is 1, the roles are swapped.
- R6: The count drops by one after every completed write cycle. A programmed count of N gives exactly N transfers.
- R7: When the count reaches zero, the enable bit clears (`ch_en` goes low) and later requests are not serviced.
- R8: `irq` goes high at terminal count and stays high until a control write with bit 5 = 1 or with bit 0 = 1.
- R9: In word mode (control bit 2 = 1), `bus_word` is 1 and address bit 0 is forced to 0. In byte mode the address is passed through unchanged.
- R10: A request that arrives while the channel is disabled or in the middle of a transfer is held as one pending request. That request is serviced after the transfer finishes, or once the channel is enabled. Several such requests collapse into one.
- R11: Writes to the memory-address, offset and count registers are ignored while a transfer is in progress.
- R12: While `bus_valid` is high and `bus_ready` is low, the address, direction and write data stay stable, and `bus_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 memory address, 1 peripheral offset, 2 count, 3 control |
| cfg_wdata | input | 24 | Register write data |
| xfer_req | input | 1 | Transfer request, one cycle per request |
| bus_valid | output | 1 | Bus cycle offered |
| bus_ready | input | 1 | Bus cycle accepted |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = 16-bit cycle, 0 = byte cycle |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_ready on a read |
| ch_en | output | 1 | Channel enable bit |
| irq | output | 1 | Transfer-end interrupt, level |

## Verification
The main transfer path is tried with every pairing of the two directions and the two sizes. The patterns include odd addresses, an all-ones memory address, an all-zero offset, and slave stalls of zero to three cycles. Together these separate a swapped source and destination, a missing top-page fill, a lost word alignment, a byte lane leak and a stall that corrupts the held cycle. Because the count differs between patterns, the bench can also find an off-by-one in terminal-count detection. Directed runs cover the following:
- requests made while the mode bits are incomplete
- requests made mid-transfer
- register rewrites made mid-transfer
- the request left pending after terminal count
- both ways of clearing the interrupt

// File: rtl/dmafx_pkg.sv
package dmafx_pkg;

  // register select codes on the configuration port
  localparam logic [1:0] SEL_MEM  = 2'd0;
  localparam logic [1:0] SEL_IO   = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // control register bit positions
  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_WORD = 2;
  localparam int CB_RPE  = 3;
  localparam int CB_IE   = 4;
  localparam int CB_ICLR = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic en;
    logic dir;
    logic word;
    logic rpe;
    logic ie;
  } ctrl_t;

endpackage

// File: rtl/dmafx_regs.sv
module dmafx_regs
  import dmafx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IO_W-1:0]   io_addr,
  output ctrl_t             ctrl,
  output logic              irq,
  output logic              active
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_dec;
  logic             ctrl_wr;
  logic             data_wr;

  assign count_dec = count - CNT_ONE;
  assign ctrl_wr   = cfg_we && (cfg_sel == SEL_CTRL);
  assign data_wr   = cfg_we && !busy;
  assign active    = ctrl.en && ctrl.rpe && ctrl.ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      io_addr  <= '0;
      count    <= '0;
      ctrl     <= '0;
      irq      <= 1'b0;
    end else begin
      if (data_wr) begin
        case (cfg_sel)
          SEL_MEM: mem_addr <= cfg_wdata;
          SEL_IO:  io_addr  <= cfg_wdata[IO_W-1:0];
          SEL_CNT: count    <= cfg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        ctrl.en   <= cfg_wdata[CB_EN];
        ctrl.dir  <= cfg_wdata[CB_DIR];
        ctrl.word <= cfg_wdata[CB_WORD];
        ctrl.rpe  <= cfg_wdata[CB_RPE];
        ctrl.ie   <= cfg_wdata[CB_IE];
        if (cfg_wdata[CB_ICLR] || cfg_wdata[CB_EN]) begin
          irq <= 1'b0;
        end
      end
      // terminal count has the last word over a control write
      if (xfer_done) begin
        count <= count_dec;
        if (count_dec == CNT_ZERO) begin
          ctrl.en <= 1'b0;
          irq     <= 1'b1;
        end
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (count == $past(count) - CNT_ONE)); // R6

  AST_TERMINAL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && count == CNT_ONE) |=> (irq && !ctrl.en)); // R7

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> irq); // R8

  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mem_addr) && $stable(io_addr))); // R11

endmodule

// File: rtl/dmafx_req.sv
module dmafx_req (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic take,
  output logic pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else begin
      pend <= (pend && !take) || xfer_req;
    end
  end

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> pend); // R10

endmodule

// File: rtl/dmafx_seq.sv
module dmafx_seq
  import dmafx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic              active,
  input  logic              cfg_dir,
  input  logic              cfg_word,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [IO_W-1:0]   io_addr,
  output logic              take,
  output logic              busy,
  output logic              xfer_done,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int PAGE_W = ADDR_W - IO_W;
  localparam int LANES  = DATA_W / 8;

  seq_state_e        state, state_n;
  logic              dir_q;
  logic              word_q;
  logic [DATA_W-1:0] hold_q;
  logic              use_io;
  logic [ADDR_W-1:0] raw_addr;

  assign take      = (state == ST_IDLE) && pend && active;
  assign busy      = (state != ST_IDLE);
  assign xfer_done = (state == ST_WRITE) && bus_ready;
  assign bus_valid = busy;
  assign bus_write = (state == ST_WRITE);
  assign bus_word  = word_q;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:  if (take)      state_n = ST_READ;
      ST_READ:  if (bus_ready) state_n = ST_WRITE;
      ST_WRITE: if (bus_ready) state_n = ST_IDLE;
      default:                 state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dir_q  <= 1'b0;
      word_q <= 1'b0;
      hold_q <= '0;
    end else begin
      state <= state_n;
      if (take) begin
        dir_q  <= cfg_dir;
        word_q <= cfg_word;
      end
      if (state == ST_READ && bus_ready) begin
        hold_q <= bus_rdata;
      end
    end
  end

  // peripheral side is read when dir=1, written when dir=0
  assign use_io   = (state == ST_READ) ? dir_q : !dir_q;
  assign raw_addr = use_io ? {{PAGE_W{1'b1}}, io_addr} : mem_addr;
  assign bus_addr = word_q ? {raw_addr[ADDR_W-1:1], 1'b0} : raw_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign bus_wdata[7:0] = hold_q[7:0];
    end else begin : g_high
      assign bus_wdata[g*8 +: 8] = word_q ? hold_q[g*8 +: 8] : 8'h00;
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))); // R12

  AST_IO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_write != dir_q)) |-> (bus_addr[ADDR_W-1 -: PAGE_W] == {PAGE_W{1'b1}})); // R4

  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_word) |-> !bus_addr[0]); // R9

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_ready) |=> (bus_valid && bus_write)); // R2

endmodule

// File: rtl/fixed_dma_channel.sv
module fixed_dma_channel
  import dmafx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              xfer_req,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              ch_en,
  output logic              irq
);

  logic              pend;
  logic              take;
  logic              busy;
  logic              xfer_done;
  logic              active;
  logic [ADDR_W-1:0] mem_addr;
  logic [IO_W-1:0]   io_addr;
  ctrl_t             ctrl;

  assign ch_en = ctrl.en;

  dmafx_regs #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .xfer_done (xfer_done),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .ctrl      (ctrl),
    .irq       (irq),
    .active    (active)
  );

  dmafx_req u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_req (xfer_req),
    .take     (take),
    .pend     (pend)
  );

  dmafx_seq #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .active    (active),
    .cfg_dir   (ctrl.dir),
    .cfg_word  (ctrl.word),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .take      (take),
    .busy      (busy),
    .xfer_done (xfer_done),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: tb/fixed_dma_channel_tb.sv
module fixed_dma_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [23:0] cfg_wdata = '0;
  logic        xfer_req = 1'b0;
  logic        bus_valid, bus_write, bus_word, ch_en, irq;
  logic        bus_ready = 1'b0;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  int errors = 0;
  int checks = 0;
  int lat = 0;
  int wcnt = 0;
  int stab_err = 0;
  int log_n = 0;
  bit finished = 0;
  logic [23:0] first_addr;
  logic        log_wr[64];
  logic        log_word[64];
  logic [23:0] log_addr[64];
  logic [15:0] log_data[64];

  always #5 clk = ~clk;

  fixed_dma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xfer_req(xfer_req), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_en(ch_en), .irq(irq)
  );

  function automatic logic [15:0] rd_fn(input logic [23:0] a);
    return {a[7:0], a[15:8]} ^ {a[23:16], 8'h5A};
  endfunction

  assign bus_rdata = rd_fn(bus_addr);

  // bus slave with programmable stall, logs every accepted cycle
  always @(negedge clk) begin
    if (bus_valid) begin
      if (wcnt == 0) first_addr = bus_addr;
      else if (bus_addr != first_addr) stab_err++;
      if (wcnt >= lat) begin
        bus_ready = 1'b1;
        if (log_n < 64) begin
          log_wr[log_n]   = bus_write;
          log_word[log_n] = bus_word;
          log_addr[log_n] = bus_addr;
          log_data[log_n] = bus_wdata;
        end
        log_n++;
        wcnt = 0;
      end else begin
        bus_ready = 1'b0;
        wcnt++;
      end
    end else begin
      bus_ready = 1'b0;
      wcnt = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 600 && log_n < n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic prog(input logic [23:0] m, input logic [15:0] io, input logic [15:0] c, input logic [5:0] ctl);
    wr_reg(2'd0, m);
    wr_reg(2'd1, {8'h00, io});
    wr_reg(2'd2, {8'h00, c});
    wr_reg(2'd3, {18'h0, ctl});
  endtask

  // {dir, word, lat[1:0], mem[23:0], io[15:0], cnt[15:0]}
  localparam bit [59:0] VECS [4] = '{
    {1'b0, 1'b0, 2'd0, 24'h123457, 16'h0041, 16'd3},
    {1'b1, 1'b1, 2'd2, 24'h800A13, 16'hC00F, 16'd2},
    {1'b0, 1'b1, 2'd1, 24'h002000, 16'h1234, 16'd4},
    {1'b1, 1'b0, 2'd3, 24'hFFFFFF, 16'h0000, 16'd1}
  };

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(ch_en == 1'b0, "R7 reset enable", 32'(ch_en), 0);
    check(irq == 1'b0, "R8 reset irq", 32'(irq), 0);
    check(bus_valid == 1'b0, "R12 reset valid", 32'(bus_valid), 0);

    // table walk over direction, size and stall patterns
    for (int v = 0; v < 4; v++) begin
      logic        dir, word;
      logic [23:0] mem, src, dst, mem_e, io_e;
      logic [15:0] io, cnt, exp_d;
      {dir, word} = VECS[v][59:58];
      lat  = int'(VECS[v][57:56]);
      mem  = VECS[v][55:32];
      io   = VECS[v][31:16];
      cnt  = VECS[v][15:0];
      mem_e = word ? {mem[23:1], 1'b0} : mem;
      io_e  = word ? {8'hFF, io[15:1], 1'b0} : {8'hFF, io};
      src = dir ? io_e : mem_e;
      dst = dir ? mem_e : io_e;
      exp_d = word ? rd_fn(src) : {8'h00, rd_fn(src)[7:0]};
      prog(mem, io, cnt, {1'b0, 1'b1, 1'b1, word, dir, 1'b1});
      log_n = 0;
      for (int k = 0; k < int'(cnt); k++) begin
        pulse_req();
        wait_log(2 * (k + 1));
        check(log_wr[2*k] == 1'b0 && log_addr[2*k] == src, dir ? "R5 read side" : "R3 read side",
              32'(log_addr[2*k]), 32'(src));
        check(log_wr[2*k+1] == 1'b1 && log_addr[2*k+1] == dst, dir ? "R3 write side" : "R4 write side",
              32'(log_addr[2*k+1]), 32'(dst));
        check(log_data[2*k+1] == exp_d, "R2 write data", 32'(log_data[2*k+1]), 32'(exp_d));
        check(log_word[2*k] == word, "R9 size", 32'(log_word[2*k]), 32'(word));
        check(ch_en == (k < int'(cnt) - 1), "R6 enable after transfer", 32'(ch_en), 32'(k < int'(cnt) - 1));
      end
      check(log_n == 2 * int'(cnt), "R6 transfer total", 32'(log_n), 32'(2 * int'(cnt)));
      check(ch_en == 1'b0, "R7 terminal disable", 32'(ch_en), 0);
      check(irq == 1'b1, "R8 terminal irq", 32'(irq), 1);
      wr_reg(2'd3, 24'h000020);
      @(negedge clk);
      check(irq == 1'b0, "R8 clear by bit5", 32'(irq), 0);
    end
    check(stab_err == 0, "R12 stalled address stable", 32'(stab_err), 0);

    // R1: repeat-enable missing, request must wait
    lat = 0;
    prog(24'h000100, 16'h0200, 16'd1, 6'b010001);
    log_n = 0;
    pulse_req();
    repeat (20) @(negedge clk);
    check(log_n == 0, "R1 no service without mode bits", 32'(log_n), 0);
    // R10: the held request goes out once the mode is complete
    wr_reg(2'd3, 24'h000019);
    wait_log(2);
    check(log_n == 2, "R10 held request serviced on enable", 32'(log_n), 2);
    check(irq == 1'b1, "R8 irq after held request", 32'(irq), 1);

    // R7: request after terminal count is not serviced
    log_n = 0;
    pulse_req();
    repeat (20) @(negedge clk);
    check(log_n == 0, "R7 no service after terminal", 32'(log_n), 0);
    check(irq == 1'b1, "R8 irq held", 32'(irq), 1);
    // R8: re-enable clears irq; R10: stale request fires
    wr_reg(2'd2, 24'h000001);
    wr_reg(2'd3, 24'h000019);
    check(irq == 1'b0, "R8 clear by enable", 32'(irq), 0);
    wait_log(2);
    check(log_n == 2, "R10 pending kept across disable", 32'(log_n), 2);
    wr_reg(2'd3, 24'h000020);

    // R10: several requests during a transfer collapse into one
    lat = 3;
    prog(24'h004000, 16'h0010, 16'd3, 6'b011001);
    log_n = 0;
    pulse_req();
    @(negedge clk);
    pulse_req();
    pulse_req();
    wait_log(4);
    repeat (30) @(negedge clk);
    check(log_n == 4, "R10 collapse to one pending", 32'(log_n), 4);
    check(ch_en == 1'b1, "R10 still enabled", 32'(ch_en), 1);
    pulse_req();
    wait_log(6);
    check(ch_en == 1'b0, "R6 third transfer ends", 32'(ch_en), 0);
    wr_reg(2'd3, 24'h000020);

    // R11: address and count writes during a transfer are dropped
    prog(24'h00AA00, 16'h0055, 16'd2, 6'b011001);
    log_n = 0;
    pulse_req();
    while (!bus_valid) @(negedge clk);
    wr_reg(2'd0, 24'h00BB00);
    wr_reg(2'd2, 24'h000009);
    wait_log(2);
    pulse_req();
    wait_log(4);
    check(log_addr[2] == 24'h00AA00, "R11 address write ignored", 32'(log_addr[2]), 32'h00AA00);
    check(ch_en == 1'b0, "R11 count write ignored", 32'(ch_en), 0);
    check(log_n == 4, "R11 transfer total", 32'(log_n), 4);
    check(log_addr[3] == 24'hFF0055 && log_data[3] == {8'h00, rd_fn(24'h00AA00)[7:0]},
          "R4 byte odd offset", 32'(log_addr[3]), 32'hFF0055);
    check(stab_err == 0, "R12 stall stability", 32'(stab_err), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule